// File: doc/BRIEF.md
# Serial Component Video Byte Demultiplexer and Range Limiter

This block takes an 8-bit stream of multiplexed component video at twice the pixel rate, one byte per clock. It looks for the four-byte timing reference codes that mark the start and end of each active line. From each code it takes the field, vertical-blank and horizontal-blank bits. Between a start-of-active code and the end of the active window, it sorts the bytes into a luma channel and a chroma channel. A phase flag tells whether the current chroma sample is Cb or Cr.

Outside the active window, the luma output holds the black code 0x10 and the chroma output holds the neutral code 0x80. Inside the window, every sample is forced into the legal range. Luma is clipped one way and chroma another. Chroma may arrive as offset binary or as two's complement, and a static configuration input selects which. Downstream filters and encoders consume the outputs directly. The valid flag acts as the composite blank signal.

Top module: `bt656_demux`

## Requirements
- R1: A timing code is the byte sequence 0xFF, 0x00, 0x00, XY. In XY, bit 6 is the field, bit 5 is vertical blank and bit 4 is horizontal blank (1 = end-of-active, 0 = start-of-active). `field_flag`, `v_flag` and `h_flag` take these bits on the clock edge that samples XY, and they hold them until the next code.
- R2: After a start-of-active code with bit 5 = 0, the next ACTIVE_LEN bytes (default 1440) are active samples. `pix_valid` is high on the edge that samples each of them and low on every other edge, including the edge that samples XY.
- R3: Active bytes alternate chroma, luma, chroma, luma, starting with chroma at index 0. Chroma samples alternate Cb then Cr. `c_is_cr` is 0 for Cb and 1 for Cr. A chroma byte updates only `c_out` and a luma byte updates only `y_out`.
- R4: On every edge where `pix_valid` is low, `y_out` is 0x10 and `c_out` is 0x80.
- R5: An active luma byte below 16 gives 16, a byte of 255 gives 254, and any other value passes unchanged.
- R6: An active chroma value (after R7) of 0 gives 1, a value of 255 gives 254, and any other value passes unchanged.
- R7: When `cfg_chroma_tc` is 1, each active chroma byte has its MSB inverted before the R6 limit. When it is 0, the byte is used as is.
- R8: A start-of-active code with bit 5 = 1 opens no active window, and `pix_valid` stays low.
- R9: Each start-of-active code restarts the sample index, even in the middle of a window, so the first chroma byte after it is always Cb.
- R10: A timing code that arrives inside the window and is not a start-of-active code with bit 5 = 0 closes the window at once.
- R11: After reset, `pix_valid` = 0, `y_out` = 0x10, `c_out` = 0x80, `c_is_cr` = 0, `h_flag` = 1, `v_flag` = 1 and `field_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Multiplexed video byte |
| cfg_chroma_tc | input | 1 | 1: chroma arrives as two's complement |
| y_out | output | 8 | Limited luma or blank code |
| c_out | output | 8 | Limited chroma (offset binary) or neutral code |
| c_is_cr | output | 1 | Current chroma sample is Cr |
| pix_valid | output | 1 | Sample is inside the active window (blank flag) |
| h_flag | output | 1 | Horizontal blank bit of the last timing code |
| v_flag | output | 1 | Vertical blank bit of the last timing code |
| field_flag | output | 1 | Field bit of the last timing code |

## Verification
The assertions check the output invariants on every cycle. Outside the window the blank codes must be present. Inside it, luma must lie in 16..254 and chroma must never be 0 or 255. The valid flag must never be high during vertical blank, and no valid run may be longer than ACTIVE_LEN. The flags must track the XY bits, and the window must start on Cb two cycles after an opening code. Some behaviour only the bench scenarios can show. These are the exact clipped values and the MSB inversion, the Cb/Cr alternation over a line, and the window closing after exactly 1440 bytes. The same holds for the restart after a mid-window code and the early close on an end code.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

  localparam logic [7:0] LUMA_BLANK   = 8'h10;
  localparam logic [7:0] CHROMA_BLANK = 8'h80;
  localparam logic [7:0] LUMA_FLOOR   = 8'd16;

  // Convert a chroma byte to offset binary.
  function automatic logic [7:0] chroma_to_ob(input logic [7:0] raw, input logic is_tc);
    chroma_to_ob = is_tc ? {~raw[7], raw[6:0]} : raw;
  endfunction

  // Luma: raise values below the floor, pull the top code down by one.
  function automatic logic [7:0] luma_limit(input logic [7:0] v);
    if (v < LUMA_FLOOR)    luma_limit = LUMA_FLOOR;
    else if (v == 8'hFF)   luma_limit = 8'hFE;
    else                   luma_limit = v;
  endfunction

  // Chroma: remove only the two extreme codes.
  function automatic logic [7:0] chroma_limit(input logic [7:0] v);
    if (v == 8'h00)        chroma_limit = 8'h01;
    else if (v == 8'hFF)   chroma_limit = 8'hFE;
    else                   chroma_limit = v;
  endfunction

endpackage

// File: rtl/bt656_trs_detect.sv
module bt656_trs_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] din,
  output logic       trs_hit,
  output logic       xy_eav,
  output logic       xy_vblank,
  output logic       h_flag,
  output logic       v_flag,
  output logic       field_flag
);
  logic [7:0] hist1, hist2, hist3;

  assign trs_hit   = (hist3 == 8'hFF) && (hist2 == 8'h00) && (hist1 == 8'h00);
  assign xy_eav    = din[4];
  assign xy_vblank = din[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist1      <= 8'h00;
      hist2      <= 8'h00;
      hist3      <= 8'h00;
      h_flag     <= 1'b1;
      v_flag     <= 1'b1;
      field_flag <= 1'b0;
    end else begin
      hist1 <= din;
      hist2 <= hist1;
      hist3 <= hist2;
      if (trs_hit) begin
        h_flag     <= din[4];
        v_flag     <= din[5];
        field_flag <= din[6];
      end
    end
  end
endmodule

// File: rtl/bt656_window.sv
module bt656_window #(
  parameter int ACTIVE_LEN = 1440,
  localparam int IDX_W = $clog2(ACTIVE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trs_hit,
  input  logic             xy_eav,
  input  logic             xy_vblank,
  output logic             win_start,
  output logic             win_active,
  output logic [IDX_W-1:0] win_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ACTIVE_LEN - 1);

  assign win_start = trs_hit && !xy_eav && !xy_vblank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_active <= 1'b0;
      win_idx    <= '0;
    end else if (trs_hit) begin
      win_active <= win_start;
      win_idx    <= '0;
    end else if (win_active) begin
      if (win_idx == LAST_IDX) win_active <= 1'b0;
      win_idx <= win_idx + 1'b1;
    end
  end
endmodule

// File: rtl/bt656_sample_clip.sv
module bt656_sample_clip
  import bt656_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] din,
  input  logic       cfg_chroma_tc,
  input  logic       in_active,
  input  logic       is_chroma,
  input  logic       cr_phase,
  output logic [7:0] y_out,
  output logic [7:0] c_out,
  output logic       c_is_cr,
  output logic       pix_valid
);
  logic [7:0] luma_lim, chroma_lim;

  assign luma_lim   = luma_limit(din);
  assign chroma_lim = chroma_limit(chroma_to_ob(din, cfg_chroma_tc));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_out     <= LUMA_BLANK;
      c_out     <= CHROMA_BLANK;
      c_is_cr   <= 1'b0;
      pix_valid <= 1'b0;
    end else begin
      pix_valid <= in_active;
      if (!in_active) begin
        y_out   <= LUMA_BLANK;
        c_out   <= CHROMA_BLANK;
        c_is_cr <= 1'b0;
      end else if (is_chroma) begin
        c_out   <= chroma_lim;
        c_is_cr <= cr_phase;
      end else begin
        y_out   <= luma_lim;
      end
    end
  end
endmodule

// File: rtl/bt656_demux.sv
module bt656_demux #(
  parameter int ACTIVE_LEN = 1440
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] din,
  input  logic       cfg_chroma_tc,
  output logic [7:0] y_out,
  output logic [7:0] c_out,
  output logic       c_is_cr,
  output logic       pix_valid,
  output logic       h_flag,
  output logic       v_flag,
  output logic       field_flag
);
  localparam int IDX_W = $clog2(ACTIVE_LEN);

  // Named internal events, visible to the bound checker.
  logic             trs_hit;
  logic             xy_eav;
  logic             xy_vblank;
  logic             win_start;
  logic             win_active;
  logic [IDX_W-1:0] win_idx;
  logic             byte_active;

  bt656_trs_detect u_trs (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .trs_hit    (trs_hit),
    .xy_eav     (xy_eav),
    .xy_vblank  (xy_vblank),
    .h_flag     (h_flag),
    .v_flag     (v_flag),
    .field_flag (field_flag)
  );

  bt656_window #(.ACTIVE_LEN(ACTIVE_LEN)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .trs_hit    (trs_hit),
    .xy_eav     (xy_eav),
    .xy_vblank  (xy_vblank),
    .win_start  (win_start),
    .win_active (win_active),
    .win_idx    (win_idx)
  );

  // The XY byte of a code is never video, even inside a window.
  assign byte_active = win_active && !trs_hit;

  bt656_sample_clip u_clip (
    .clk           (clk),
    .rst_n         (rst_n),
    .din           (din),
    .cfg_chroma_tc (cfg_chroma_tc),
    .in_active     (byte_active),
    .is_chroma     (!win_idx[0]),
    .cr_phase      (win_idx[1]),
    .y_out         (y_out),
    .c_out         (c_out),
    .c_is_cr       (c_is_cr),
    .pix_valid     (pix_valid)
  );
endmodule

// File: rtl/bt656_demux_chk.sv
module bt656_demux_chk #(
  parameter int ACTIVE_LEN = 1440
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] din,
  input logic [7:0] y_out,
  input logic [7:0] c_out,
  input logic       c_is_cr,
  input logic       pix_valid,
  input logic       h_flag,
  input logic       v_flag,
  input logic       field_flag,
  input logic       trs_hit,
  input logic       win_start
);
  localparam int RUN_W = $clog2(ACTIVE_LEN + 2);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_len <= '0;
    else if (pix_valid) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  // R1
  flags_track_xy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trs_hit) |-> (h_flag == $past(din[4])) && (v_flag == $past(din[5]))
                       && (field_flag == $past(din[6])));
  // R2
  run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RUN_W'(ACTIVE_LEN));
  // R4
  blank_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (y_out == 8'h10) && (c_out == 8'h80));
  // R5
  luma_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (y_out >= 8'd16) && (y_out != 8'hFF));
  // R6
  chroma_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (c_out != 8'h00) && (c_out != 8'hFF));
  // R8
  no_valid_in_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_flag |-> !pix_valid);
  // R9
  start_on_cb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_start, 2) |-> pix_valid && !c_is_cr);
  // R3
  cr_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_is_cr |-> pix_valid);
endmodule

bind bt656_demux bt656_demux_chk #(.ACTIVE_LEN(ACTIVE_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .din        (din),
  .y_out      (y_out),
  .c_out      (c_out),
  .c_is_cr    (c_is_cr),
  .pix_valid  (pix_valid),
  .h_flag     (h_flag),
  .v_flag     (v_flag),
  .field_flag (field_flag),
  .trs_hit    (trs_hit),
  .win_start  (win_start)
);

// File: tb/bt656_demux_test.sv
module bt656_demux_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic       cfg_chroma_tc = 1'b0;
  logic [7:0] y_out, c_out;
  logic       c_is_cr, pix_valid, h_flag, v_flag, field_flag;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  bt656_demux uut (
    .clk(clk), .rst_n(rst_n), .din(din), .cfg_chroma_tc(cfg_chroma_tc),
    .y_out(y_out), .c_out(c_out), .c_is_cr(c_is_cr), .pix_valid(pix_valid),
    .h_flag(h_flag), .v_flag(v_flag), .field_flag(field_flag)
  );

  // {chroma in, luma in, tc mode, expected chroma, expected luma}
  localparam int NVEC = 9;
  localparam logic [32:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b0, 8'h01, 8'h10},
    {8'hFF, 8'hFF, 1'b0, 8'hFE, 8'hFE},
    {8'h80, 8'h0F, 1'b0, 8'h80, 8'h10},
    {8'h01, 8'h10, 1'b0, 8'h01, 8'h10},
    {8'hFE, 8'hFE, 1'b0, 8'hFE, 8'hFE},
    {8'h00, 8'hEB, 1'b1, 8'h80, 8'hEB},
    {8'h80, 8'h80, 1'b1, 8'h01, 8'h80},
    {8'h7F, 8'h05, 1'b1, 8'hFE, 8'h10},
    {8'h3C, 8'hC8, 1'b1, 8'hBC, 8'hC8}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one byte; on return the outputs reflect it.
  task automatic send(input logic [7:0] b);
    din = b;
    @(negedge clk);
  endtask

  task automatic send_code(input logic [7:0] xy);
    send(8'hFF); send(8'h00); send(8'h00); send(xy);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 valid", pix_valid, 0);
    check("R11 y", y_out, 8'h10);
    check("R11 c", c_out, 8'h80);
    check("R11 cr", c_is_cr, 0);
    check("R11 flags", {h_flag, v_flag, field_flag}, 3'b110);

    // R1 start code, field 0, no vblank (XY 0x80)
    send_code(8'h80);
    check("R1 flags after SAV", {h_flag, v_flag, field_flag}, 3'b000);
    check("R2 XY not valid", pix_valid, 0);

    // Vector walk: R3 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      cfg_chroma_tc = VEC[i][16];
      send(VEC[i][32:25]);
      check("R2 valid chroma", pix_valid, 1);
      check("R6/R7 chroma value", c_out, VEC[i][15:8]);
      check("R3 phase", c_is_cr, i % 2);
      send(VEC[i][24:17]);
      check("R5 luma value", y_out, VEC[i][7:0]);
      check("R3 chroma held on luma", c_out, VEC[i][15:8]);
    end
    cfg_chroma_tc = 1'b0;

    // Fill up to the end of the window
    for (int k = 2 * NVEC; k < 1440; k++) send((k % 2) ? 8'h40 : 8'h90);
    check("R2 last sample valid", pix_valid, 1);
    check("R2 last is luma", y_out, 8'h40);
    send(8'h22);
    check("R2 window closed after 1440", pix_valid, 0);
    check("R4 luma blank", y_out, 8'h10);
    check("R4 chroma blank", c_out, 8'h80);

    // R1 end code (XY 0x9D)
    send_code(8'h9D);
    check("R1 h after EAV", {h_flag, v_flag, field_flag}, 3'b100);

    // R8 start code inside vertical blank (XY 0xAB)
    send_code(8'hAB);
    check("R1 v after vblank SAV", {h_flag, v_flag}, 2'b01);
    for (int k = 0; k < 8; k++) begin
      send(8'h00);
      check("R8 no valid in vblank", pix_valid, 0);
      check("R4 luma blank vblank", y_out, 8'h10);
    end

    // Field 1 start (XY 0xC7), then restart mid-window
    send_code(8'hC7);
    check("R1 field bit", field_flag, 1);
    send(8'h20); send(8'h30); send(8'h40);
    check("R3 second chroma is Cr", c_is_cr, 1);
    send(8'h50); send(8'h60);
    send(8'hFF); send(8'h00); send(8'h00);
    send(8'hC7);
    check("R9 XY byte not valid", pix_valid, 0);
    send(8'h55);
    check("R9 restart valid", pix_valid, 1);
    check("R9 restart on Cb", c_is_cr, 0);
    check("R9 restart chroma", c_out, 8'h55);
    send(8'h66); send(8'h77);
    check("R9 then Cr", c_is_cr, 1);

    // R10 end code mid-window closes it
    send(8'h88);
    send_code(8'hDA);
    check("R10 closed on EAV", pix_valid, 0);
    send(8'h33);
    check("R10 stays closed", pix_valid, 0);
    check("R4 luma blank after close", y_out, 8'h10);

    finish_run();
  end
endmodule